// File: doc/BRIEF.md
# Half-Duplex Smart Card Character Link Controller

This block holds the control and status state for a half-duplex smart card character UART. The host drives plain strobes: it loads a direction bit, arms a last-character flag, writes characters to a one-entry transmit holding register and pops characters from a receive FIFO. It watches four status flags: direction, last-character, FIFO-empty and a shared buffer bit. The shared bit means "holding register empty" while transmitting and "receive buffer full" while receiving. A bit-level serializer behind the block takes characters over a valid/ready handshake and reports a done strobe for each one sent. It delivers each received character as a single-cycle valid strobe.

Once the last character of a command has gone out, the block turns the link round by itself. The host arms the last-character flag before it writes the final byte. When the serializer reports that byte done, hardware clears the direction and the flag together and the FIFO starts empty. The receive FIFO has eight physical entries. A 3-bit field sets how many of them count as "full", so the host can choose how many characters it collects before it is interrupted.

Back-pressure rules: the transmit stream `ser_tx_valid`/`ser_tx_data` stays stable until the cycle in which `ser_tx_ready` is high, and the character transfers on that cycle. The receive strobe `ser_rx_valid` has no ready. A character that arrives while the FIFO holds at least the threshold count is discarded. So is a character that arrives in transmit mode.

Top module: `sc_uart_ctl`

## Requirements
- R1: Reset leaves the direction bit at 0 (receive). A `cfg_dir_wr` pulse loads `cfg_dir_val`, where 1 means transmit and 0 means receive. A `host_tx_wr` pulse in receive mode has no effect. An `ser_rx_valid` strobe in transmit mode has no effect.
- R2: In transmit mode a `host_tx_wr` loads the holding register. `ser_tx_valid` then stays high with that byte on `ser_tx_data` until a cycle in which `ser_tx_ready` is high. After that cycle it is low.
- R3: In transmit mode `st_tbe_rbf` reads 1 when the holding register is empty. This is true on entry to transmit and in the cycle after the serializer accepts a character that was not marked last. A write clears it in the following cycle.
- R4: A `cfg_lct_set` pulse sets `st_lct`. A character written while `st_lct` is 1 is marked last, and its acceptance by the serializer leaves `st_tbe_rbf` at 0.
- R5: A `ser_tx_done` pulse for a character marked last clears `st_dir` and `st_lct` in the same cycle. A done pulse for an unmarked character leaves `st_dir` at 1.
- R6: On any change from transmit to receive, the FIFO content is discarded and `st_fifo_empty` reads 1 in the first receive cycle.
- R7: `st_fifo_empty` reads 0 from the cycle after a character is captured into an empty FIFO.
- R8: `cfg_depth` value v sets a threshold of v+1, from 1 to 8. In receive mode `st_tbe_rbf` is 1 while the FIFO count is at least the threshold. A character that arrives in that state is discarded.
- R9: A `host_rx_rd` pulse in receive mode with the FIFO not empty removes the head character. A pop from a FIFO at the threshold clears `st_tbe_rbf` in the next cycle.
- R10: Characters come out of `host_rx_data` in arrival order. `st_ctrl_ready` is 0 in the cycle after a pop or after a capture into an empty FIFO, and it is 0 while the FIFO is empty. Otherwise it is 1, and `host_rx_data` holds the head character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir_wr | input | 1 | Load strobe for the direction bit |
| cfg_dir_val | input | 1 | Direction value: 1 transmit, 0 receive |
| cfg_lct_set | input | 1 | Arms the last-character flag |
| cfg_depth | input | 3 | FIFO threshold minus one |
| host_tx_wr | input | 1 | Transmit holding register write strobe |
| host_tx_data | input | 8 | Byte to transmit |
| host_rx_rd | input | 1 | Receive FIFO pop strobe |
| host_rx_data | output | 8 | Head character of the receive FIFO |
| ser_tx_valid | output | 1 | Character offered to the serializer |
| ser_tx_ready | input | 1 | Serializer accepts the offered character |
| ser_tx_data | output | 8 | Character offered to the serializer |
| ser_tx_done | input | 1 | Serializer finished sending a character |
| ser_rx_valid | input | 1 | Received character strobe |
| ser_rx_data | input | 8 | Received character |
| st_dir | output | 1 | Direction bit, 1 transmit |
| st_lct | output | 1 | Last-character flag |
| st_fifo_empty | output | 1 | Receive FIFO empty |
| st_tbe_rbf | output | 1 | Holding empty (transmit) or receive buffer full (receive) |
| st_ctrl_ready | output | 1 | host_rx_data holds a valid head character |

## Verification
Most internal faults show up on a status pin within one or two cycles. A lost last-character mark leaves `st_dir` high after the done pulse. A wrong mark sets `st_tbe_rbf` in the cycle after acceptance. A threshold that is off by one moves the rising edge of `st_tbe_rbf` by one capture, and a missing flush leaves `st_fifo_empty` low on the first receive cycle. Pointer or head-register faults stay hidden until the host pops. They then appear as a wrong byte on `host_rx_data` in the cycle where `st_ctrl_ready` returns high, or as a dropped character that should have been counted, which shows as an early empty flag.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  typedef enum logic {
    LINK_RX = 1'b0,
    LINK_TX = 1'b1
  } link_dir_e;
endpackage

// File: rtl/sc_dir_ctl.sv
module sc_dir_ctl
  import sc_uart_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_dir_wr,
  input  logic      cfg_dir_val,
  input  logic      cfg_lct_set,
  input  logic      turn,
  output link_dir_e dir_q,
  output logic      lct_q,
  output logic      enter_rx,
  output logic      enter_tx
);
  link_dir_e dir_d;
  logic      lct_d;

  always_comb begin
    dir_d = dir_q;
    lct_d = lct_q;
    if (cfg_dir_wr) dir_d = cfg_dir_val ? LINK_TX : LINK_RX;
    if (cfg_lct_set) lct_d = 1'b1;
    // hardware turnaround wins over a host write in the same cycle
    if (turn) begin
      dir_d = LINK_RX;
      lct_d = 1'b0;
    end
  end

  assign enter_rx = (dir_q == LINK_TX) && (dir_d == LINK_RX);
  assign enter_tx = (dir_q == LINK_RX) && (dir_d == LINK_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= LINK_RX;
      lct_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      lct_q <= lct_d;
    end
  end
endmodule

// File: rtl/sc_tx_hold.sv
module sc_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              enter_tx,
  input  logic              lct,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_ready,
  input  logic              ser_done,
  output logic              ser_valid,
  output logic [DATA_W-1:0] ser_data,
  output logic              tbe,
  output logic              hold_last,
  output logic              turn
);
  logic              full_q;
  logic              last_q;
  logic              tbe_q;
  logic              fly_last_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_ok;
  logic              acc;

  assign wr_ok     = tx_mode && wr;
  assign ser_valid = tx_mode && full_q;
  assign ser_data  = data_q;
  assign acc       = ser_valid && ser_ready;
  assign tbe       = tbe_q;
  assign hold_last = last_q;
  assign turn      = tx_mode && ser_done && fly_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      last_q     <= 1'b0;
      tbe_q      <= 1'b1;
      fly_last_q <= 1'b0;
      data_q     <= '0;
    end else if (enter_tx) begin
      full_q     <= 1'b0;
      last_q     <= 1'b0;
      tbe_q      <= 1'b1;
      fly_last_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        full_q <= 1'b1;
        data_q <= wr_data;
        last_q <= lct;
        tbe_q  <= 1'b0;
      end else if (acc) begin
        full_q <= 1'b0;
        tbe_q  <= !last_q;
      end
      if (acc) fly_last_q <= last_q;
      else if (ser_done) fly_last_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              flush,
  input  logic [THR_W-1:0]  cfg_depth,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd,
  output logic              empty,
  output logic              at_thr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count, thr;
  logic              push, pop, head_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign thr    = CNT_W'(cfg_depth) + CNT_W'(1);
  assign empty  = (count == '0);
  assign at_thr = (count >= thr);
  assign push   = rx_mode && in_valid && !at_thr && (count < CNT_W'(DEPTH));
  assign pop    = rx_mode && rd && !empty;
  assign out_ready = head_ok && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      head_ok  <= 1'b0;
      out_data <= '0;
    end else begin
      out_data <= mem[rd_ptr];
      head_ok  <= !(flush || pop || (push && empty));
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push) wr_ptr <= ptr_inc(wr_ptr);
        if (pop)  rd_ptr <= ptr_inc(rd_ptr);
        count <= count + CNT_W'(push) - CNT_W'(pop);
      end
    end
  end
endmodule

// File: rtl/sc_uart_ctl.sv
module sc_uart_ctl
  import sc_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir_wr,
  input  logic              cfg_dir_val,
  input  logic              cfg_lct_set,
  input  logic [THR_W-1:0]  cfg_depth,
  input  logic              host_tx_wr,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_rd,
  output logic [DATA_W-1:0] host_rx_data,
  output logic              ser_tx_valid,
  input  logic              ser_tx_ready,
  output logic [DATA_W-1:0] ser_tx_data,
  input  logic              ser_tx_done,
  input  logic              ser_rx_valid,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic              st_dir,
  output logic              st_lct,
  output logic              st_fifo_empty,
  output logic              st_tbe_rbf,
  output logic              st_ctrl_ready
);
  link_dir_e dir_q;
  logic      lct_q, enter_rx, enter_tx, turn;
  logic      tx_mode, tbe, hold_last_w, at_thr;

  assign tx_mode = (dir_q == LINK_TX);

  sc_dir_ctl u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dir_wr (cfg_dir_wr),
    .cfg_dir_val(cfg_dir_val),
    .cfg_lct_set(cfg_lct_set),
    .turn       (turn),
    .dir_q      (dir_q),
    .lct_q      (lct_q),
    .enter_rx   (enter_rx),
    .enter_tx   (enter_tx)
  );

  sc_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_mode  (tx_mode),
    .enter_tx (enter_tx),
    .lct      (lct_q),
    .wr       (host_tx_wr),
    .wr_data  (host_tx_data),
    .ser_ready(ser_tx_ready),
    .ser_done (ser_tx_done),
    .ser_valid(ser_tx_valid),
    .ser_data (ser_tx_data),
    .tbe      (tbe),
    .hold_last(hold_last_w),
    .turn     (turn)
  );

  sc_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_mode  (!tx_mode),
    .flush    (enter_rx),
    .cfg_depth(cfg_depth),
    .in_valid (ser_rx_valid),
    .in_data  (ser_rx_data),
    .rd       (host_rx_rd),
    .empty    (st_fifo_empty),
    .at_thr   (at_thr),
    .out_data (host_rx_data),
    .out_ready(st_ctrl_ready)
  );

  assign st_dir     = tx_mode;
  assign st_lct     = lct_q;
  assign st_tbe_rbf = tx_mode ? tbe : at_thr;
endmodule

// File: rtl/sc_uart_ctl_chk.sv
module sc_uart_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_dir_wr,
  input logic host_tx_wr,
  input logic host_rx_rd,
  input logic ser_tx_valid,
  input logic ser_tx_ready,
  input logic st_dir,
  input logic st_lct,
  input logic st_fifo_empty,
  input logic st_tbe_rbf,
  input logic st_ctrl_ready,
  input logic hold_last
);
  p_tx_valid_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_valid |-> st_dir);

  p_rx_entry_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_dir) |-> st_fifo_empty);

  p_tbe_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_dir && ser_tx_valid && ser_tx_ready && !hold_last && !host_tx_wr && !cfg_dir_wr)
      |=> (st_tbe_rbf || !st_dir));

  p_lct_no_tbe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_tx_valid && ser_tx_ready && hold_last && !cfg_dir_wr) |=> !st_tbe_rbf);

  p_lct_falls_with_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_lct) |-> !st_dir);

  p_empty_not_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_dir && st_fifo_empty) |-> !st_tbe_rbf);

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rx_rd && !st_dir && !st_fifo_empty) |=> !st_ctrl_ready);

  p_ready_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_ctrl_ready |-> !st_fifo_empty);
endmodule

bind sc_uart_ctl sc_uart_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_dir_wr   (cfg_dir_wr),
  .host_tx_wr   (host_tx_wr),
  .host_rx_rd   (host_rx_rd),
  .ser_tx_valid (ser_tx_valid),
  .ser_tx_ready (ser_tx_ready),
  .st_dir       (st_dir),
  .st_lct       (st_lct),
  .st_fifo_empty(st_fifo_empty),
  .st_tbe_rbf   (st_tbe_rbf),
  .st_ctrl_ready(st_ctrl_ready),
  .hold_last    (hold_last_w)
);

// File: tb/sim_sc_uart_ctl.sv
`timescale 1ns/1ps
module sim_sc_uart_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_dir_wr = 0, cfg_dir_val = 0, cfg_lct_set = 0;
  logic [2:0] cfg_depth = 3'd0;
  logic       host_tx_wr = 0, host_rx_rd = 0;
  logic [7:0] host_tx_data = 0, host_rx_data;
  logic       ser_tx_valid, ser_tx_ready = 0, ser_tx_done = 0;
  logic [7:0] ser_tx_data;
  logic       ser_rx_valid = 0;
  logic [7:0] ser_rx_data = 0;
  logic       st_dir, st_lct, st_fifo_empty, st_tbe_rbf, st_ctrl_ready;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  sc_uart_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_dir_wr(cfg_dir_wr), .cfg_dir_val(cfg_dir_val), .cfg_lct_set(cfg_lct_set),
    .cfg_depth(cfg_depth),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .ser_tx_valid(ser_tx_valid), .ser_tx_ready(ser_tx_ready), .ser_tx_data(ser_tx_data),
    .ser_tx_done(ser_tx_done),
    .ser_rx_valid(ser_rx_valid), .ser_rx_data(ser_rx_data),
    .st_dir(st_dir), .st_lct(st_lct), .st_fifo_empty(st_fifo_empty),
    .st_tbe_rbf(st_tbe_rbf), .st_ctrl_ready(st_ctrl_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_dir(input logic v);
    @(negedge clk); cfg_dir_wr = 1; cfg_dir_val = v;
    @(negedge clk); cfg_dir_wr = 0;
  endtask

  task automatic wr_tx(input logic [7:0] d);
    @(negedge clk); host_tx_wr = 1; host_tx_data = d;
    @(negedge clk); host_tx_wr = 0;
  endtask

  task automatic accept;
    @(negedge clk); ser_tx_ready = 1;
    @(negedge clk); ser_tx_ready = 0;
  endtask

  task automatic done;
    @(negedge clk); ser_tx_done = 1;
    @(negedge clk); ser_tx_done = 0;
  endtask

  task automatic rx_char(input logic [7:0] d);
    @(negedge clk); ser_rx_valid = 1; ser_rx_data = d;
    @(negedge clk); ser_rx_valid = 0;
  endtask

  task automatic pop;
    @(negedge clk); host_rx_rd = 1;
    @(negedge clk); host_rx_rd = 0;
  endtask

  task automatic t_reset;
    check("R1 reset dir", st_dir, 0);
    check("R1 reset lct", st_lct, 0);
    check("R6 reset empty", st_fifo_empty, 1);
    check("R8 reset rbf", st_tbe_rbf, 0);
    check("R10 reset ready", st_ctrl_ready, 0);
    check("R2 reset valid", ser_tx_valid, 0);
  endtask

  task automatic t_tx_plain;
    set_dir(1);
    check("R1 dir tx", st_dir, 1);
    check("R3 tbe on entry", st_tbe_rbf, 1);
    wr_tx(8'hA5);
    check("R3 tbe cleared by write", st_tbe_rbf, 0);
    check("R2 valid", ser_tx_valid, 1);
    check("R2 data", ser_tx_data, 8'hA5);
    @(negedge clk);
    check("R2 held without ready", ser_tx_valid, 1);
    accept;
    check("R2 valid after accept", ser_tx_valid, 0);
    check("R3 tbe after accept", st_tbe_rbf, 1);
    done;
    check("R5 unmarked done keeps tx", st_dir, 1);
  endtask

  task automatic t_lct;
    @(negedge clk); cfg_lct_set = 1;
    @(negedge clk); cfg_lct_set = 0;
    check("R4 lct set", st_lct, 1);
    wr_tx(8'h3C);
    accept;
    check("R4 no tbe for last", st_tbe_rbf, 0);
    check("R5 dir before done", st_dir, 1);
    done;
    check("R5 dir cleared", st_dir, 0);
    check("R5 lct cleared", st_lct, 0);
    check("R6 empty on entry", st_fifo_empty, 1);
    wr_tx(8'h77);
    check("R1 write ignored in rx", ser_tx_valid, 0);
  endtask

  task automatic t_thr3;
    cfg_depth = 3'd2;
    rx_char(8'h11);
    check("R7 empty clears", st_fifo_empty, 0);
    check("R10 ready low after first capture", st_ctrl_ready, 0);
    check("R8 below thr", st_tbe_rbf, 0);
    rx_char(8'h22);
    rx_char(8'h33);
    check("R8 thr3 full", st_tbe_rbf, 1);
    rx_char(8'h44);
    check("R10 ready", st_ctrl_ready, 1);
    check("R10 head", host_rx_data, 8'h11);
    pop;
    check("R10 ready low after read", st_ctrl_ready, 0);
    check("R9 rbf cleared", st_tbe_rbf, 0);
    @(negedge clk);
    check("R10 ready back", st_ctrl_ready, 1);
    check("R10 second", host_rx_data, 8'h22);
    pop; @(negedge clk);
    check("R10 third", host_rx_data, 8'h33);
    pop;
    check("R8 overflow dropped", st_fifo_empty, 1);
    check("R10 ready when empty", st_ctrl_ready, 0);
  endtask

  task automatic t_thr1;
    cfg_depth = 3'd0;
    rx_char(8'h5A);
    check("R8 thr1 full", st_tbe_rbf, 1);
    pop;
    check("R9 thr1 empty", st_fifo_empty, 1);
  endtask

  task automatic t_thr8;
    cfg_depth = 3'd7;
    for (int i = 0; i < 7; i++) rx_char(8'h80 + 8'(i));
    check("R8 thr8 not yet", st_tbe_rbf, 0);
    rx_char(8'h87);
    check("R8 thr8 full", st_tbe_rbf, 1);
    rx_char(8'hEE);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R10 order thr8", host_rx_data, 8'h80 + 8'(i));
      pop;
    end
    check("R8 ninth dropped", st_fifo_empty, 1);
  endtask

  task automatic t_flush;
    rx_char(8'h01);
    rx_char(8'h02);
    set_dir(1);
    rx_char(8'h03);
    set_dir(0);
    check("R6 flush on entry", st_fifo_empty, 1);
    check("R1 rx ignored in tx", st_ctrl_ready, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: got %0d expected below 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_tx_plain;
    t_lct;
    t_thr3;
    t_thr1;
    t_thr8;
    t_flush;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule